// File: doc/BRIEF.md
# Network Controller Interrupt Status and Mask Block

This block holds the interrupt state of a network controller as two byte-wide channels, one for the transmitter and one for the receiver. Each channel has a status register and a mask register. Single-cycle event pulses from the datapath OR bits into a status register. Software clears status bits by writing ones to them. Each channel drives a level interrupt output that goes high when an event leaves a masked status bit pending. It goes low again when a later register write leaves no pending bit inside a channel-specific release subset.

A mode input picks between two controller variants. In legacy mode a transmit status write can clear only the low nibble, and transmit status comes out of reset with its top (ready) bit set. In enhanced mode every written bit clears, and transmit status resets to zero. Mask registers store the full byte, but a read returns only a fixed subset of bits for each channel. The register port is a plain address, write-enable and write-data port with combinational read data.

Top module: `netirq_regs`

## Requirements
- R1: A synchronous reset makes transmit status 0x80 when `enh_mode` is 0 and 0x00 when it is 1, and clears receive status, both masks and both interrupt outputs.
- R2: An event pulse ORs its bits into the channel status on the next clock edge. All eight transmit event bits are accepted. Receive event bits 6 and 5 are discarded, so receive status bits 6:5 always read 0.
- R3: A write to offset 0 (transmit status) clears every bit written as one when `enh_mode` is 1, and only the ones among bits 3:0 when `enh_mode` is 0.
- R4: A write to offset 2 (receive status) clears only the bits written as one within 0x8F. Bit 4 is never cleared by a write.
- R5: Writes to offset 1 (transmit mask) and offset 3 (receive mask) store the byte. Reading offset 1 returns the stored value AND 0xAF, and reading offset 3 returns the stored value AND 0x9F.
- R6: One cycle after an event pulse, the channel interrupt is high if the new status AND mask is nonzero. If the AND is zero, the event leaves the interrupt unchanged. A write by itself never raises an interrupt.
- R7: One cycle after a status or mask write to a channel, its interrupt is low if status AND mask AND the release subset is zero. The subset is 0x0F for transmit and 0x8F for receive. Otherwise the interrupt level is held.
- R8: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set. If the event then raises the interrupt, the write does not release it.
- R9: Reads are combinational and have no side effects: offset 0 returns transmit status and offset 2 returns receive status, and repeated reads leave all state as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enh_mode | input | 1 | 0 selects legacy rules, 1 selects enhanced rules |
| reg_addr | input | 2 | Register offset for reads and writes |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data (ones clear status bits) |
| reg_rdata | output | 8 | Read data of the addressed register |
| tx_evt | input | 8 | Transmit event pulse bits |
| rx_evt | input | 8 | Receive event pulse bits |
| tx_irq | output | 1 | Transmit interrupt level |
| rx_irq | output | 1 | Receive interrupt level |

## Verification
The bench looks for the asymmetric interrupt behaviour: writing a mask that already covers a pending bit must not raise the line, and a clear must release it even while a masked bit outside the release subset, such as transmit ready or receive bit 4, is still pending. A design that evaluates a single status-AND-mask term would raise the line on mask writes or keep it stuck high. The bench also sends an event and a clear of the same bit in one cycle, where a clear-wins design loses the event and drops the interrupt. It switches modes to catch legacy clear protection applied in enhanced mode, or the reverse. It sends receive events on the undefined bits and reads masks back, where a design that stores or reports unfiltered values would show the extra bits.

// File: rtl/netirq_pkg.sv
package netirq_pkg;

    localparam int REG_W = 8;
    localparam int ADR_W = 2;
    localparam int NCH   = 2;
    localparam int CH_TX = 0;
    localparam int CH_RX = 1;

    typedef enum logic [ADR_W-1:0] {
        OFS_TX_STAT = 2'd0,
        OFS_TX_MASK = 2'd1,
        OFS_RX_STAT = 2'd2,
        OFS_RX_MASK = 2'd3
    } reg_ofs_e;

    typedef struct packed {
        logic stat_wr;
        logic mask_wr;
    } chan_wr_t;

    localparam logic [REG_W-1:0] TX_RST_LEGACY = 8'h80;
    localparam logic [REG_W-1:0] TX_CLR_LEGACY = 8'h0F;
    localparam logic [REG_W-1:0] TX_CLR_ENH    = 8'hFF;
    localparam logic [REG_W-1:0] RX_CLR        = 8'h8F;
    localparam logic [REG_W-1:0] TX_RD_MASK    = 8'hAF;
    localparam logic [REG_W-1:0] RX_RD_MASK    = 8'h9F;
    localparam logic [REG_W-1:0] TX_REL_MASK   = 8'h0F;
    localparam logic [REG_W-1:0] RX_REL_MASK   = 8'h8F;
    localparam logic [REG_W-1:0] TX_EVT_VALID  = 8'hFF;
    localparam logic [REG_W-1:0] RX_EVT_VALID  = 8'h9F;

    function automatic logic [REG_W-1:0] chan_rel_mask(int ch);
        return (ch == CH_TX) ? TX_REL_MASK : RX_REL_MASK;
    endfunction

    function automatic logic [REG_W-1:0] chan_rd_mask(int ch);
        return (ch == CH_TX) ? TX_RD_MASK : RX_RD_MASK;
    endfunction

    function automatic logic [REG_W-1:0] chan_evt_valid(int ch);
        return (ch == CH_TX) ? TX_EVT_VALID : RX_EVT_VALID;
    endfunction

    function automatic logic [REG_W-1:0] tx_clr_mask(logic enh);
        return enh ? TX_CLR_ENH : TX_CLR_LEGACY;
    endfunction

    function automatic logic [REG_W-1:0] tx_rst_val(logic enh);
        return enh ? '0 : TX_RST_LEGACY;
    endfunction

    // Event assertion has priority; release is considered only after a write.
    function automatic logic irq_next(logic cur, logic ev_any, logic wr_any,
                                      logic [REG_W-1:0] act,
                                      logic [REG_W-1:0] rel);
        if (ev_any && (act != '0))
            return 1'b1;
        if (wr_any && ((act & rel) == '0))
            return 1'b0;
        return cur;
    endfunction

endpackage

// File: rtl/netirq_chan.sv
module netirq_chan
    import netirq_pkg::*;
#(
    parameter logic [REG_W-1:0] REL_MASK = 8'h0F
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] rst_val,
    input  logic [REG_W-1:0] evt,
    input  logic [REG_W-1:0] clr_mask,
    input  chan_wr_t         wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] stat_q,
    output logic [REG_W-1:0] mask_q,
    output logic             irq_q
);

    logic [REG_W-1:0] clr_bits;
    logic [REG_W-1:0] stat_d;
    logic [REG_W-1:0] mask_d;
    logic             irq_d;

    always_comb begin
        clr_bits = wr.stat_wr ? (wdata & clr_mask) : '0;
        // set after clear: a coincident event survives
        stat_d   = (stat_q & ~clr_bits) | evt;
        mask_d   = wr.mask_wr ? wdata : mask_q;
        irq_d    = irq_next(irq_q, evt != '0, wr.stat_wr | wr.mask_wr,
                            stat_d & mask_d, REL_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= rst_val;
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= stat_d;
            mask_q <= mask_d;
            irq_q  <= irq_d;
        end
    end

endmodule

// File: rtl/netirq_rdmux.sv
module netirq_rdmux
    import netirq_pkg::*;
(
    input  logic [ADR_W-1:0]          addr,
    input  logic [NCH-1:0][REG_W-1:0] stat,
    input  logic [NCH-1:0][REG_W-1:0] mask,
    output logic [REG_W-1:0]          rdata
);

    logic [NCH-1:0][REG_W-1:0] mask_vis;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_vis
        assign mask_vis[ch] = mask[ch] & chan_rd_mask(ch);
    end

    always_comb begin
        unique case (reg_ofs_e'(addr))
            OFS_TX_STAT: rdata = stat[CH_TX];
            OFS_TX_MASK: rdata = mask_vis[CH_TX];
            OFS_RX_STAT: rdata = stat[CH_RX];
            OFS_RX_MASK: rdata = mask_vis[CH_RX];
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/netirq_regs.sv
module netirq_regs
    import netirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enh_mode,
    input  logic [ADR_W-1:0] reg_addr,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [REG_W-1:0] tx_evt,
    input  logic [REG_W-1:0] rx_evt,
    output logic             tx_irq,
    output logic             rx_irq
);

    logic [NCH-1:0][REG_W-1:0] evt_raw;
    logic [NCH-1:0][REG_W-1:0] clr_m;
    logic [NCH-1:0][REG_W-1:0] rst_v;
    logic [NCH-1:0][REG_W-1:0] stat_q;
    logic [NCH-1:0][REG_W-1:0] mask_q;
    logic [NCH-1:0]            irq_q;
    chan_wr_t [NCH-1:0]        wr;

    always_comb begin
        evt_raw[CH_TX] = tx_evt;
        evt_raw[CH_RX] = rx_evt;
        clr_m[CH_TX]   = tx_clr_mask(enh_mode);
        clr_m[CH_RX]   = RX_CLR;
        rst_v[CH_TX]   = tx_rst_val(enh_mode);
        rst_v[CH_RX]   = '0;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam logic [ADR_W-1:0] OFS_STAT = ADR_W'(2 * ch);
        localparam logic [ADR_W-1:0] OFS_MASK = ADR_W'(2 * ch + 1);

        assign wr[ch].stat_wr = reg_we && (reg_addr == OFS_STAT);
        assign wr[ch].mask_wr = reg_we && (reg_addr == OFS_MASK);

        netirq_chan #(
            .REL_MASK (chan_rel_mask(ch))
        ) u_chan (
            .clk      (clk),
            .rst      (rst),
            .rst_val  (rst_v[ch]),
            .evt      (evt_raw[ch] & chan_evt_valid(ch)),
            .clr_mask (clr_m[ch]),
            .wr       (wr[ch]),
            .wdata    (reg_wdata),
            .stat_q   (stat_q[ch]),
            .mask_q   (mask_q[ch]),
            .irq_q    (irq_q[ch])
        );
    end

    netirq_rdmux u_rdmux (
        .addr  (reg_addr),
        .stat  (stat_q),
        .mask  (mask_q),
        .rdata (reg_rdata)
    );

    assign tx_irq = irq_q[CH_TX];
    assign rx_irq = irq_q[CH_RX];

endmodule

// File: rtl/netirq_regs_chk.sv
module netirq_regs_chk
    import netirq_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      enh_mode,
    input logic                      reg_we,
    input logic [ADR_W-1:0]          reg_addr,
    input logic [REG_W-1:0]          tx_evt,
    input logic [REG_W-1:0]          rx_evt,
    input logic                      tx_irq,
    input logic                      rx_irq,
    input logic [NCH-1:0][REG_W-1:0] stat_q
);

    // R6
    tx_irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_irq) |-> $past(tx_evt != '0));

    // R6
    rx_irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_irq) |-> $past((rx_evt & RX_EVT_VALID) != '0));

    // R7
    tx_irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_irq) |-> $past(reg_we && (reg_addr == 2'd0 || reg_addr == 2'd1)));

    // R7
    rx_irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_irq) |-> $past(reg_we && (reg_addr == 2'd2 || reg_addr == 2'd3)));

    // R8
    tx_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_evt != '0) |=> ((stat_q[CH_TX] & $past(tx_evt)) == $past(tx_evt)));

    // R3
    tx_legacy_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 2'd0 && !enh_mode && tx_evt == '0)
        |=> (stat_q[CH_TX][REG_W-1:4] == $past(stat_q[CH_TX][REG_W-1:4])));

    // R4
    rx_bit4_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 2'd2 && !rx_evt[4])
        |=> (stat_q[CH_RX][4] == $past(stat_q[CH_RX][4])));

    // R2
    rx_undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
        stat_q[CH_RX][6:5] == 2'b00);

endmodule

bind netirq_regs netirq_regs_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .enh_mode (enh_mode),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .tx_evt   (tx_evt),
    .rx_evt   (rx_evt),
    .tx_irq   (tx_irq),
    .rx_irq   (rx_irq),
    .stat_q   (stat_q)
);

// File: tb/sim_netirq_regs.sv
module sim_netirq_regs;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enh_mode = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] tx_evt = 8'h00;
    logic [7:0] rx_evt = 8'h00;
    logic [7:0] reg_rdata;
    logic       tx_irq;
    logic       rx_irq;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    netirq_regs u0 (
        .clk       (clk),
        .rst       (rst),
        .enh_mode  (enh_mode),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tx_evt    (tx_evt),
        .rx_evt    (rx_evt),
        .tx_irq    (tx_irq),
        .rx_irq    (rx_irq)
    );

    // act: 0 none, 1 register write, 2 tx event, 3 rx event
    // {act, act_addr, act_data, chk_addr, chk_exp, exp_tx_irq, exp_rx_irq}
    localparam int NV = 15;
    localparam logic [23:0] VEC [NV] = '{
        {2'd1, 2'd1, 8'hFF, 2'd1, 8'hAF, 1'b0, 1'b0},
        {2'd2, 2'd0, 8'h04, 2'd0, 8'h84, 1'b1, 1'b0},
        {2'd1, 2'd0, 8'hF0, 2'd0, 8'h84, 1'b1, 1'b0},
        {2'd1, 2'd0, 8'h04, 2'd0, 8'h80, 1'b0, 1'b0},
        {2'd1, 2'd3, 8'hFF, 2'd3, 8'h9F, 1'b0, 1'b0},
        {2'd3, 2'd0, 8'hFF, 2'd2, 8'h9F, 1'b0, 1'b1},
        {2'd1, 2'd2, 8'hFF, 2'd2, 8'h10, 1'b0, 1'b0},
        {2'd3, 2'd0, 8'h08, 2'd2, 8'h18, 1'b0, 1'b1},
        {2'd1, 2'd3, 8'h00, 2'd3, 8'h00, 1'b0, 1'b0},
        {2'd3, 2'd0, 8'h01, 2'd2, 8'h19, 1'b0, 1'b0},
        {2'd1, 2'd3, 8'h10, 2'd3, 8'h10, 1'b0, 1'b0},
        {2'd3, 2'd0, 8'h02, 2'd2, 8'h1B, 1'b0, 1'b1},
        {2'd1, 2'd2, 8'h8F, 2'd2, 8'h10, 1'b0, 1'b0},
        {2'd3, 2'd0, 8'h60, 2'd2, 8'h10, 1'b0, 1'b0},
        {2'd0, 2'd0, 8'h00, 2'd1, 8'hAF, 1'b0, 1'b0}
    };

    string row_req [NV] = '{
        "R5 mask store", "R2 R6 tx event", "R3 legacy upper bits kept",
        "R7 release with ready pending", "R5 rx mask readback",
        "R2 R6 rx event", "R4 R7 rx clear", "R6 rx event assert",
        "R7 mask write release", "R6 masked event no assert",
        "R7 mask write no assert", "R6 assert via pending bit4",
        "R4 R7 release with bit4 pending", "R2 undefined rx bits",
        "R9 idle read"
    };

    task automatic check_rd(input logic [1:0] a, input logic [7:0] exp,
                            input logic etx, input logic erx, input string req);
        reg_addr = a;
        #1;
        n_chk++;
        if (reg_rdata !== exp) begin
            n_err++;
            $display("FAIL %s: rdata at offset %0d got %02h expected %02h",
                     req, a, reg_rdata, exp);
        end
        n_chk++;
        if (tx_irq !== etx) begin
            n_err++;
            $display("FAIL %s: tx_irq got %0b expected %0b", req, tx_irq, etx);
        end
        n_chk++;
        if (rx_irq !== erx) begin
            n_err++;
            $display("FAIL %s: rx_irq got %0b expected %0b", req, rx_irq, erx);
        end
    endtask

    task automatic do_act(input logic [1:0] kind, input logic [1:0] a,
                          input logic [7:0] d);
        @(negedge clk);
        case (kind)
            2'd1: begin reg_we = 1'b1; reg_addr = a; reg_wdata = d; end
            2'd2: tx_evt = d;
            2'd3: rx_evt = d;
            default: ;
        endcase
        @(negedge clk);
        reg_we = 1'b0;
        reg_wdata = 8'h00;
        tx_evt = 8'h00;
        rx_evt = 8'h00;
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        // R1: legacy reset values
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_rd(2'd0, 8'h80, 1'b0, 1'b0, "R1 legacy tx status");
        check_rd(2'd1, 8'h00, 1'b0, 1'b0, "R1 tx mask");
        check_rd(2'd2, 8'h00, 1'b0, 1'b0, "R1 rx status");
        check_rd(2'd3, 8'h00, 1'b0, 1'b0, "R1 rx mask");

        for (int i = 0; i < NV; i++) begin
            do_act(VEC[i][23:22], VEC[i][21:20], VEC[i][19:12]);
            check_rd(VEC[i][11:10], VEC[i][9:2], VEC[i][1], VEC[i][0], row_req[i]);
        end

        // R8: event and clear on the same bit in one cycle
        @(negedge clk);
        tx_evt = 8'h08;
        reg_we = 1'b1;
        reg_addr = 2'd0;
        reg_wdata = 8'h08;
        @(negedge clk);
        tx_evt = 8'h00;
        reg_we = 1'b0;
        reg_wdata = 8'h00;
        check_rd(2'd0, 8'h88, 1'b1, 1'b0, "R8 set wins over clear");

        // R9: repeated reads change nothing
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            reg_addr = 2'(k);
        end
        @(negedge clk);
        check_rd(2'd0, 8'h88, 1'b1, 1'b0, "R9 reads without side effects");

        // R3: enhanced mode clears all written bits
        @(negedge clk);
        enh_mode = 1'b1;
        do_act(2'd1, 2'd0, 8'hFF);
        check_rd(2'd0, 8'h00, 1'b0, 1'b0, "R3 enhanced full clear");

        // R6: enhanced event on the ready bit
        do_act(2'd2, 2'd0, 8'h80);
        check_rd(2'd0, 8'h80, 1'b1, 1'b0, "R6 enhanced ready event");

        // R7: mask write releases when subset is clear
        do_act(2'd1, 2'd1, 8'h7F);
        check_rd(2'd1, 8'h2F, 1'b0, 1'b0, "R7 R5 mask write release");

        // R1: enhanced reset values
        reset_dut();
        check_rd(2'd0, 8'h00, 1'b0, 1'b0, "R1 enhanced tx status");
        check_rd(2'd1, 8'h00, 1'b0, 1'b0, "R1 tx mask after reset");
        check_rd(2'd2, 8'h00, 1'b0, 1'b0, "R1 rx status after reset");
        check_rd(2'd3, 8'h00, 1'b0, 1'b0, "R1 rx mask after reset");

        finished = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule